// File: doc/BRIEF.md
# Host command channel for remote 16-bit registers

This block lets software reach 16-bit registers on a remote device through a serial engine that sits behind it. Software writes one 32-bit command word. The word says whether the access is a read or a write. It also gives the register's halfword address and, for a write, the data. The block then asks the serial engine to carry out the access. It tracks the transfer in a four-state machine and publishes that state in a status word, which software polls.

A read result stays frozen in the status word, and the machine waits in its valid-clear state until software acknowledges the result. A write completes without any acknowledge. A new command is accepted only while the machine is idle. The status word also reports whether the serial engine is idle and whether software has marked initialisation as complete.

Remote byte addresses sit on a stride of two. Software therefore places the byte address shifted right by one in the command.

Top module: `hostreg_chan`

## Requirements
- R1: A command word written while idle is decoded as follows: bit 31 is the write flag (1 = write, 0 = read), bits 30:16 are the halfword address, and bits 15:0 are the write data. While the request is raised, these fields appear on `eng_write`, `eng_addr` and `eng_wdata`.
- R2: The status word places read data in bits 15:0, the machine state code in bits 18:16, the request-pending flag in bit 19, the engine-idle flag in bit 20 and the init-complete flag in bit 21. Bits 31:22 read as zero.
- R3: The state codes are idle = 0, request = 2, wait-for-data = 4 and wait-for-valid-clear = 6. An accepted command moves idle to request one cycle after the write.
- R4: In the request state `eng_req` stays high and request-pending (bit 19) stays set until `eng_ack`. On `eng_ack` the machine enters wait-for-data and clears request-pending.
- R5: In wait-for-data, an `eng_done` pulse on a read captures `eng_rdata` into status bits 15:0 and moves the machine to wait-for-valid-clear.
- R6: In wait-for-valid-clear, the state and the read data hold until a register write to selector 1 with data bit 0 = 1. That write returns the machine to idle and leaves the read data unchanged. A selector-1 write with bit 0 = 0 does nothing.
- R7: In wait-for-data, an `eng_done` pulse on a write returns the machine directly to idle and leaves the read data unchanged.
- R8: A command write (selector 0) in any state other than idle is ignored. The state, the outgoing address, data and direction, and the later result are all unaffected.
- R9: Engine-idle (bit 20) equals the inverse of `eng_busy`. Init-complete (bit 21) holds bit 0 of the most recent write to selector 2.
- R10: Reset forces the idle state and clears the read data, request-pending and init-complete.
- R11: Writes to selector 3 have no effect.

Register selector encoding for `reg_sel`: 0 = command, 1 = valid-clear, 2 = init-complete, 3 = unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | 32 | Register write data |
| status_o | output | 32 | Status and read-data word |
| eng_req | output | 1 | Request toward serial engine |
| eng_write | output | 1 | Direction of request, 1 = write |
| eng_addr | output | 15 | Halfword address of request |
| eng_wdata | output | 16 | Write data of request |
| eng_ack | input | 1 | Engine accepted the request |
| eng_done | input | 1 | Engine finished the transfer |
| eng_rdata | input | 16 | Read data, valid with eng_done |
| eng_busy | input | 1 | Engine has a transfer in flight |

## Verification
A corrupted state register would show up in status bits 18:16 at the very next sample after the stimulus, either as a code outside the four legal values or as the wrong one of them. A read that is lost or released too early would show up as changed data or an idle code while software has not yet written the valid-clear. A command that leaks in while the machine is busy would change `eng_addr` or `eng_write` within one cycle. The bench samples every one of these outputs in the cycle right after each stimulus.

// File: rtl/hostreg_chan.sv
module hostreg_chan #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   status_o,
  output logic          eng_req,
  output logic          eng_write,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_wdata,
  input  logic          eng_ack,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_rdata,
  input  logic          eng_busy
);
  localparam int SW = DW + 6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd2,
    S_WFDI = 3'd4,
    S_WFVC = 3'd6
  } st_t;

  st_t           st;
  logic          pend, init_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;

  logic cmd_hit, vclr_hit, init_hit;
  assign cmd_hit  = reg_wr && reg_sel == 2'd0;
  assign vclr_hit = reg_wr && reg_sel == 2'd1 && reg_wdata[0];
  assign init_hit = reg_wr && reg_sel == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      init_q <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (init_hit) init_q <= reg_wdata[0];
      unique case (st)
        S_IDLE: if (cmd_hit) begin
          st     <= S_REQ;
          pend   <= 1'b1;
          wr_q   <= reg_wdata[31];
          addr_q <= reg_wdata[16 +: AW];
          wdat_q <= reg_wdata[DW-1:0];
        end
        S_REQ: if (eng_ack) begin
          st   <= S_WFDI;
          pend <= 1'b0;
        end
        S_WFDI: if (eng_done) begin
          if (wr_q) st <= S_IDLE;
          else begin
            st     <= S_WFVC;
            rdat_q <= eng_rdata;
          end
        end
        S_WFVC: if (vclr_hit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign eng_req   = st == S_REQ;
  assign eng_write = wr_q;
  assign eng_addr  = addr_q;
  assign eng_wdata = wdat_q;

  logic [SW-1:0] stat;
  assign stat = {init_q, ~eng_busy, pend, st, rdat_q};
  assign status_o = {{(32-SW){1'b0}}, stat};
endmodule

// File: rtl/hostreg_chan_chk.sv
module hostreg_chan_chk #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   status_o,
  input logic          eng_req,
  input logic          eng_write,
  input logic [AW-1:0] eng_addr,
  input logic          eng_ack,
  input logic          eng_done,
  input logic          eng_busy
);
  logic [2:0] stc;
  assign stc = status_o[DW+2:DW];

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    stc == 3'd0 || stc == 3'd2 || stc == 3'd4 || stc == 3'd6);

  a_r4_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> eng_req && status_o[DW+3]);

  a_r5_read_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (stc == 3'd4 && eng_done && !eng_write) |=> stc == 3'd6);

  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (stc == 3'd6 && !(reg_wr && reg_sel == 2'd1 && reg_wdata[0]))
      |=> stc == 3'd6 && $stable(status_o[DW-1:0]));

  a_r7_write_skips_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stc == 3'd4 && eng_done && eng_write) |=> stc == 3'd0);

  a_r8_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (stc != 3'd0) |=> $stable(eng_addr) && $stable(eng_write));
endmodule

bind hostreg_chan hostreg_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .status_o(status_o), .eng_req(eng_req),
  .eng_write(eng_write), .eng_addr(eng_addr), .eng_ack(eng_ack),
  .eng_done(eng_done), .eng_busy(eng_busy)
);

// File: tb/hostreg_chan_bench.sv
module hostreg_chan_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] status_o;
  logic        eng_req, eng_write;
  logic [14:0] eng_addr;
  logic [15:0] eng_wdata;
  logic        eng_ack = 0, eng_done = 0, eng_busy = 0;
  logic [15:0] eng_rdata = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  hostreg_chan u_hostreg_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status_o(status_o), .eng_req(eng_req),
    .eng_write(eng_write), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .eng_busy(eng_busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stw(logic init, logic eidle, logic pend,
                                      logic [2:0] s, logic [15:0] d);
    return {10'd0, init, eidle, pend, s, d};
  endfunction

  task automatic rw(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk); eng_ack = 1;
    @(negedge clk); eng_ack = 0;
  endtask

  task automatic done(logic [15:0] rd);
    @(negedge clk); eng_done = 1; eng_rdata = rd;
    @(negedge clk); eng_done = 0; eng_rdata = 16'hdead;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset status", status_o, stw(0, 1, 0, 0, 0));
    chk("R10 no request", {31'd0, eng_req}, 0);
  endtask

  task automatic t_read();
    rw(0, {1'b0, 15'h5e01, 16'h0000});
    chk("R3 R2 request state", status_o, stw(0, 1, 1, 2, 0));
    chk("R1 read decode", {eng_req, eng_write, eng_addr}, {2'b10, 15'h5e01});
    @(negedge clk);
    chk("R4 request held", {31'd0, eng_req}, 1);
    ack();
    chk("R4 wait-for-data", status_o, stw(0, 1, 0, 4, 0));
    done(16'h5aa5);
    chk("R5 parked with data", status_o, stw(0, 1, 0, 6, 16'h5aa5));
    rw(1, 32'h0);
    chk("R6 clear bit0=0 ignored", status_o, stw(0, 1, 0, 6, 16'h5aa5));
    rw(0, {1'b1, 15'h0123, 16'hbeef});
    chk("R8 cmd in clear-wait ignored", status_o, stw(0, 1, 0, 6, 16'h5aa5));
    chk("R8 addr unchanged", {17'd0, eng_addr}, {17'd0, 15'h5e01});
    rw(1, 32'h1);
    chk("R6 clear returns idle", status_o, stw(0, 1, 0, 0, 16'h5aa5));
  endtask

  task automatic t_write();
    rw(0, {1'b1, 15'h5e06, 16'ha55a});
    chk("R1 write decode", {eng_req, eng_write, eng_addr, eng_wdata},
        {2'b11, 15'h5e06, 16'ha55a});
    rw(0, {1'b0, 15'h0007, 16'h1111});
    chk("R8 cmd in request ignored", {eng_write, eng_addr, eng_wdata},
        {1'b1, 15'h5e06, 16'ha55a});
    ack();
    rw(0, {1'b0, 15'h0009, 16'h2222});
    chk("R8 cmd in wait-for-data ignored", {15'd0, eng_write, eng_addr},
        {16'd1, 15'h5e06});
    done(16'h7777);
    chk("R7 write back to idle", status_o, stw(0, 1, 0, 0, 16'h5aa5));
  endtask

  task automatic t_flags();
    rw(2, 32'h1);
    chk("R9 init set", status_o, stw(1, 1, 0, 0, 16'h5aa5));
    @(negedge clk); eng_busy = 1; #1;
    chk("R9 engine busy", status_o, stw(1, 0, 0, 0, 16'h5aa5));
    eng_busy = 0;
    rw(3, 32'hffff_ffff);
    chk("R11 selector 3 no effect", status_o, stw(1, 1, 0, 0, 16'h5aa5));
    rw(1, 32'h1);
    chk("R6 clear in idle no effect", status_o, stw(1, 1, 0, 0, 16'h5aa5));
    rw(2, 32'h0);
    chk("R9 init cleared", status_o, stw(0, 1, 0, 0, 16'h5aa5));
  endtask

  task automatic t_reset_mid();
    rw(2, 32'h1);
    rw(0, {1'b0, 15'h0042, 16'h0});
    ack(); done(16'h1234);
    chk("R5 second read", status_o, stw(1, 1, 0, 6, 16'h1234));
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R10 reset mid-transfer", status_o, stw(0, 1, 0, 0, 0));
  endtask

  initial begin
    fork
      begin
        t_reset(); t_read(); t_write(); t_flags(); t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule